// File: doc/BRIEF.md
# Watermark-Flagged Sample Buffer Pair

This block manages two circular sample buffers that share one local memory and sit between a bus and a filter-style compute engine. The input ring is filled by bus writes of 16-bit samples through a write pointer that steps by one after each write. The engine drains it and reports the offset of the oldest sample it still needs. The output ring is filled by the engine at its current destination offset and drained by bus reads through a read pointer that also steps by one.

From the pointers the block derives the free space in the input ring and the number of unread samples in the output ring. It compares each with a programmable watermark to produce an input-full flag and an output-empty flag. Both flags reach the outputs through a fixed three-stage pipeline. While a flag is low, the matching interrupt request and DMA request are raised under their own enables. Writes into a full input ring and reads from a drained output ring set sticky error bits.

Top module: `smp_buf_pair`

## Requirements
- R1: A cycle with `wr_valid` high stores `wr_data[15:0]` at memory address `in_base + wr_ptr` (truncated to AW bits), and `wr_ptr` then steps to `wr_ptr + 1`, returning to 0 when it reaches `in_size`. Bits 31:16 of `wr_data` have no effect.
- R2: Input free space is `(eng_oldest - wr_ptr - 1) mod in_size`, so one slot always stays empty. The input-full flag is 1 exactly when free space is below the threshold picked by `full_wm`, where codes 0, 1, 2 and 3 pick thresholds 1, 2, 4 and 8.
- R3: Output unread count is `(eng_dest - rd_ptr) mod out_size`. The output-empty flag is 1 exactly when the unread count is below the threshold picked by `empty_wm`, using the same code-to-threshold mapping as R2.
- R4: A change of pointers or engine offsets sampled at clock edge E0 reaches a flag at edge E3. At edges E1 and E2 the flag still shows the previous level.
- R5: `wr_irq` equals `wr_irq_en` AND NOT input-full, and `wr_dma` equals `dma_wr_en` AND NOT input-full.
- R6: `rd_irq` equals `rd_irq_en` AND NOT output-empty, and `rd_dma` equals `dma_rd_en` AND NOT output-empty.
- R7: A write made while input-full is 1 is still stored as in R1, and it sets `ovf_err`. Once set, `ovf_err` stays 1 until reset.
- R8: A read (`rd_valid` high) while the unread count is nonzero loads `rd_data` with the word at `out_base + rd_ptr` at that edge. `rd_ptr` then steps by one modulo `out_size`.
- R9: A read while the unread count is 0 leaves both `rd_data` and `rd_ptr` unchanged, and it sets `unf_err`. Once set, `unf_err` stays 1 until reset.
- R10: Asynchronous active-low reset clears both pointers, both flags, every pipeline stage, `rd_data` and both error bits.
- R11: When `eng_wr_en` is high, the edge stores `eng_wr_data` at `out_base + eng_dest`. `eng_rd_data` shows, without a clock, the word at `in_base + eng_rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_base | input | AW | Memory address of input ring slot 0 |
| in_size | input | AW | Number of slots in the input ring |
| out_base | input | AW | Memory address of output ring slot 0 |
| out_size | input | AW | Number of slots in the output ring |
| full_wm | input | 2 | Input watermark code (threshold 1, 2, 4 or 8) |
| empty_wm | input | 2 | Output watermark code (threshold 1, 2, 4 or 8) |
| wr_irq_en | input | 1 | Enables the write interrupt request |
| rd_irq_en | input | 1 | Enables the read interrupt request |
| dma_wr_en | input | 1 | Enables the DMA write request |
| dma_rd_en | input | 1 | Enables the DMA read request |
| wr_valid | input | 1 | Bus write of one sample |
| wr_data | input | BUSW | Bus write data; only the low DW bits are used |
| rd_valid | input | 1 | Bus read of one sample |
| rd_data | output | DW | Last sample read from the output ring |
| eng_oldest | input | AW | Offset of the oldest input sample the engine still needs |
| eng_rd_addr | input | AW | Offset of the input sample the engine reads |
| eng_rd_data | output | DW | Input sample at `eng_rd_addr` |
| eng_dest | input | AW | Engine's current output destination offset |
| eng_wr_en | input | 1 | Engine stores one result |
| eng_wr_data | input | DW | Result value from the engine |
| in_full | output | 1 | Input free space below the watermark |
| out_empty | output | 1 | Output unread count below the watermark |
| wr_irq | output | 1 | Write interrupt request |
| rd_irq | output | 1 | Read interrupt request |
| wr_dma | output | 1 | DMA write request |
| rd_dma | output | 1 | DMA read request |
| ovf_err | output | 1 | Sticky: a write arrived while input-full was set |
| unf_err | output | 1 | Sticky: a read arrived with no unread data |

## Verification
The bench builds the block with AW = 5, which gives a 32-word memory. The input ring is sized 5 or 9 and the output ring 4 or 11, so each ring can be filled past its capacity and wrapped in a few dozen cycles. With rings this small, every watermark code is swept against every free-space and unread level, including levels above the ring size where the flag never clears. The same runs cover the wrap of both pointers, the overflow write into a full ring and the underflow read from a drained ring. After every access the bench samples each flag two and three edges later, which pins down the pipeline lag exactly.

// File: rtl/smp_buf_pkg.sv
package smp_buf_pkg;

  // Width used for all ring arithmetic; pointers are zero-extended into it.
  localparam int PW = 16;
  typedef logic [PW-1:0] pword_t;

  // Watermark code -> threshold: 1, 2, 4 or 8.
  function automatic logic [3:0] wm_thresh(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // Distance from b forward to a on a ring of 'size' slots.
  function automatic pword_t ring_diff(input pword_t a, input pword_t b, input pword_t size);
    if (a >= b) return a - b;
    return a + size - b;
  endfunction

  // Next slot after p on a ring of 'size' slots.
  function automatic pword_t ring_next(input pword_t p, input pword_t size);
    if (p + 16'd1 >= size) return '0;
    return p + 16'd1;
  endfunction

endpackage

// File: rtl/sbp_ring_ptr.sv
module sbp_ring_ptr
  import smp_buf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [AW-1:0] size,
  output logic [AW-1:0] ptr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= AW'(ring_next(pword_t'(ptr), pword_t'(size)));
    end
  end

endmodule

// File: rtl/sbp_wm_flag.sv
module sbp_wm_flag
  import smp_buf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] level,
  input  logic [1:0]    wm_code,
  output logic          flag
);

  // Stage 1 captures the level, stage 2 compares, stage 3 drives the flag.
  logic [AW-1:0] level_q;
  logic          below_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      below_q <= 1'b0;
      flag    <= 1'b0;
    end else begin
      level_q <= level;
      below_q <= pword_t'(level_q) < pword_t'(wm_thresh(wm_code));
      flag    <= below_q;
    end
  end

endmodule

// File: rtl/smp_buf_pair.sv
module smp_buf_pair
  import smp_buf_pkg::*;
#(
  parameter int AW   = 6,
  parameter int DW   = 16,
  parameter int BUSW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   in_base,
  input  logic [AW-1:0]   in_size,
  input  logic [AW-1:0]   out_base,
  input  logic [AW-1:0]   out_size,
  input  logic [1:0]      full_wm,
  input  logic [1:0]      empty_wm,
  input  logic            wr_irq_en,
  input  logic            rd_irq_en,
  input  logic            dma_wr_en,
  input  logic            dma_rd_en,
  input  logic            wr_valid,
  input  logic [BUSW-1:0] wr_data,
  input  logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  input  logic [AW-1:0]   eng_oldest,
  input  logic [AW-1:0]   eng_rd_addr,
  output logic [DW-1:0]   eng_rd_data,
  input  logic [AW-1:0]   eng_dest,
  input  logic            eng_wr_en,
  input  logic [DW-1:0]   eng_wr_data,
  output logic            in_full,
  output logic            out_empty,
  output logic            wr_irq,
  output logic            rd_irq,
  output logic            wr_dma,
  output logic            rd_dma,
  output logic            ovf_err,
  output logic            unf_err
);

  localparam int DEPTH  = 1 << AW;
  localparam int NRINGS = 2;

  logic [DW-1:0] mem [DEPTH];

  // Named internal events, also used by the bound checker.
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW-1:0] in_free, out_unread;
  logic          rd_acc, rd_starve;
  logic [AW-1:0] wr_addr, rd_addr, eng_in_addr, eng_out_addr;
  logic          unused_hi;

  assign unused_hi = ^wr_data[BUSW-1:DW];

  assign in_free    = AW'(ring_diff(pword_t'(eng_oldest),
                                    ring_next(pword_t'(wr_ptr), pword_t'(in_size)),
                                    pword_t'(in_size)));
  assign out_unread = AW'(ring_diff(pword_t'(eng_dest), pword_t'(rd_ptr), pword_t'(out_size)));

  assign rd_acc    = rd_valid && (out_unread != '0);
  assign rd_starve = rd_valid && (out_unread == '0);

  assign wr_addr      = in_base + wr_ptr;
  assign rd_addr      = out_base + rd_ptr;
  assign eng_in_addr  = in_base + eng_rd_addr;
  assign eng_out_addr = out_base + eng_dest;

  sbp_ring_ptr #(.AW(AW)) u_wr_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (wr_valid),
    .size (in_size),
    .ptr  (wr_ptr)
  );

  sbp_ring_ptr #(.AW(AW)) u_rd_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (rd_acc),
    .size (out_size),
    .ptr  (rd_ptr)
  );

  // Ring 0 = input (free space), ring 1 = output (unread count).
  logic [AW-1:0] ring_level [NRINGS];
  logic [1:0]    ring_code  [NRINGS];
  logic          ring_flag  [NRINGS];

  assign ring_level[0] = in_free;
  assign ring_level[1] = out_unread;
  assign ring_code[0]  = full_wm;
  assign ring_code[1]  = empty_wm;

  for (genvar g = 0; g < NRINGS; g++) begin : g_flag
    sbp_wm_flag #(.AW(AW)) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .level  (ring_level[g]),
      .wm_code(ring_code[g]),
      .flag   (ring_flag[g])
    );
  end

  assign in_full   = ring_flag[0];
  assign out_empty = ring_flag[1];

  assign wr_irq = wr_irq_en && !in_full;
  assign wr_dma = dma_wr_en && !in_full;
  assign rd_irq = rd_irq_en && !out_empty;
  assign rd_dma = dma_rd_en && !out_empty;

  // Shared sample memory; a bus write wins a same-address collision.
  always_ff @(posedge clk) begin
    if (eng_wr_en) mem[eng_out_addr] <= eng_wr_data;
    if (wr_valid)  mem[wr_addr]      <= wr_data[DW-1:0];
  end

  assign eng_rd_data = mem[eng_in_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      if (rd_acc) rd_data <= mem[rd_addr];
      if (wr_valid && in_full) ovf_err <= 1'b1;
      if (rd_starve) unf_err <= 1'b1;
    end
  end

endmodule

// File: rtl/sbp_chk.sv
module sbp_chk
  import smp_buf_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    full_wm,
  input logic [1:0]    empty_wm,
  input logic [AW-1:0] in_size,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] in_free,
  input logic [AW-1:0] out_unread,
  input logic          wr_valid,
  input logic          rd_valid,
  input logic          in_full,
  input logic          out_empty,
  input logic          wr_irq,
  input logic          wr_dma,
  input logic          rd_irq,
  input logic          rd_dma,
  input logic          ovf_err,
  input logic          unf_err,
  input logic [DW-1:0] rd_data
);

  logic [1:0] since_rst;
  logic       full_d1, full_d2, full_d3;
  logic       emp_d1, emp_d2, emp_d3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      {full_d1, full_d2, full_d3} <= '0;
      {emp_d1, emp_d2, emp_d3}    <= '0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      full_d1 <= pword_t'(in_free) < pword_t'(wm_thresh(full_wm));
      full_d2 <= full_d1;
      full_d3 <= full_d2;
      emp_d1  <= pword_t'(out_unread) < pword_t'(wm_thresh(empty_wm));
      emp_d2  <= emp_d1;
      emp_d3  <= emp_d2;
    end
  end

  // R1
  wr_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(in_size) && ($past(wr_ptr) < $past(in_size))) |-> (wr_ptr < in_size));

  // R2 R4
  full_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (in_full == full_d3));

  // R3 R4
  empty_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_empty == emp_d3));

  // R5
  wr_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_full |-> (!wr_irq && !wr_dma));

  // R6
  rd_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_empty |-> (!rd_irq && !rd_dma));

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && in_full) |=> ovf_err);

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  // R9
  unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && (out_unread == '0)) |=> (unf_err && $stable(rd_data)));

  // R9
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |=> unf_err);

endmodule

bind smp_buf_pair sbp_chk #(.AW(AW), .DW(DW)) u_sbp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .full_wm   (full_wm),
  .empty_wm  (empty_wm),
  .in_size   (in_size),
  .wr_ptr    (wr_ptr),
  .in_free   (in_free),
  .out_unread(out_unread),
  .wr_valid  (wr_valid),
  .rd_valid  (rd_valid),
  .in_full   (in_full),
  .out_empty (out_empty),
  .wr_irq    (wr_irq),
  .wr_dma    (wr_dma),
  .rd_irq    (rd_irq),
  .rd_dma    (rd_dma),
  .ovf_err   (ovf_err),
  .unf_err   (unf_err),
  .rd_data   (rd_data)
);

// File: tb/test_smp_buf_pair.sv
module test_smp_buf_pair;

  localparam int AW = 5;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] in_base = 5'd2, in_size = 5'd5, out_base = 5'd16, out_size = 5'd4;
  logic [1:0]    full_wm = '0, empty_wm = '0;
  logic          wr_irq_en = 1'b1, rd_irq_en = 1'b1, dma_wr_en = 1'b1, dma_rd_en = 1'b1;
  logic          wr_valid = 1'b0, rd_valid = 1'b0, eng_wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [DW-1:0] eng_wr_data = '0;
  logic [AW-1:0] eng_oldest = '0, eng_rd_addr = '0, eng_dest = '0;
  logic [DW-1:0] rd_data, eng_rd_data;
  logic          in_full, out_empty, wr_irq, rd_irq, wr_dma, rd_dma, ovf_err, unf_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  smp_buf_pair #(.AW(AW)) i_smp_buf_pair (
    .clk(clk), .rst_n(rst_n), .in_base(in_base), .in_size(in_size),
    .out_base(out_base), .out_size(out_size), .full_wm(full_wm), .empty_wm(empty_wm),
    .wr_irq_en(wr_irq_en), .rd_irq_en(rd_irq_en), .dma_wr_en(dma_wr_en), .dma_rd_en(dma_rd_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .eng_oldest(eng_oldest), .eng_rd_addr(eng_rd_addr), .eng_rd_data(eng_rd_data),
    .eng_dest(eng_dest), .eng_wr_en(eng_wr_en), .eng_wr_data(eng_wr_data),
    .in_full(in_full), .out_empty(out_empty), .wr_irq(wr_irq), .rd_irq(rd_irq),
    .wr_dma(wr_dma), .rd_dma(rd_dma), .ovf_err(ovf_err), .unf_err(unf_err)
  );

  function automatic int mdiff(input int a, input int b, input int size);
    return ((a - b) % size + size) % size;
  endfunction

  function automatic int thr(input int code);
    return 1 << code;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rst_lo();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic rst_hi();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic eng_put(input int off, input logic [DW-1:0] d);
    @(negedge clk);
    eng_dest    = AW'(off);
    eng_wr_data = d;
    eng_wr_en   = 1'b1;
    @(negedge clk);
    eng_wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: reset state, sampled before any edge after release
    settle(2);
    rst_n = 1'b1;
    chk("R10 in_full", int'(in_full), 0);
    chk("R10 out_empty", int'(out_empty), 0);
    chk("R10 rd_data", int'(rd_data), 0);
    chk("R10 ovf_err", int'(ovf_err), 0);
    chk("R10 unf_err", int'(unf_err), 0);
    chk("R10 R5 wr_irq", int'(wr_irq), 1);
    chk("R10 R6 rd_dma", int'(rd_dma), 1);
    settle(4);
    chk("R3 out_empty after reset", int'(out_empty), 1);

    // Input ring sweep: R1 R2 R4 R5 R7 R11
    foreach (in_size[i]) ; // no-op keeps structure simple
    for (int si = 0; si < 2; si++) begin
      for (int code = 0; code < 4; code++) begin
        for (int oi = 0; oi < 2; oi++) begin
          int sz, old, wp, free, flag_now, flag_new, ovf_exp, exp_dma;
          logic [31:0] d;
          sz  = (si == 0) ? 5 : 9;
          old = (oi == 0) ? 0 : 3;
          rst_lo();
          in_size    = AW'(sz);
          full_wm    = 2'(code);
          eng_oldest = AW'(old);
          dma_wr_en  = code[0];
          rst_hi();
          settle(4);
          wp = 0;
          ovf_exp = 0;
          free = mdiff(old - 1, wp, sz);
          flag_now = (free < thr(code)) ? 1 : 0;
          chk("R2 in_full initial", int'(in_full), flag_now);
          for (int k = 0; k < sz; k++) begin
            d = {16'hA5C3 ^ 16'(k), 16'(k * 37 + sz * 3 + code)};
            if (flag_now == 1) ovf_exp = 1;
            do_write(d);
            wp = (wp + 1) % sz;
            free = mdiff(old - 1, wp, sz);
            flag_new = (free < thr(code)) ? 1 : 0;
            settle(2);
            chk("R4 in_full lag", int'(in_full), flag_now);
            settle(1);
            chk("R2 R4 in_full", int'(in_full), flag_new);
            chk("R5 wr_irq", int'(wr_irq), 1 - flag_new);
            exp_dma = (code % 2 == 1 && flag_new == 0) ? 1 : 0;
            chk("R5 wr_dma", int'(wr_dma), exp_dma);
            chk("R7 ovf_err", int'(ovf_err), ovf_exp);
            eng_rd_addr = AW'((wp - 1 + sz) % sz);
            #1;
            chk("R1 R11 stored sample", int'(eng_rd_data), int'(d[15:0]));
            flag_now = flag_new;
          end
          // R1: wrap back to offset 0
          d = {16'hFFFF, 16'(16'h7100 + sz * 16 + code)};
          if (flag_now == 1) ovf_exp = 1;
          do_write(d);
          wp = (wp + 1) % sz;
          eng_rd_addr = '0;
          #1;
          chk("R1 wrap to slot 0", int'(eng_rd_data), int'(d[15:0]));
          // R2: free space follows the engine's oldest sample
          old = (old + 2) % sz;
          eng_oldest = AW'(old);
          free = mdiff(old - 1, wp, sz);
          flag_new = (free < thr(code)) ? 1 : 0;
          settle(3);
          chk("R2 in_full after oldest moves", int'(in_full), flag_new);
          chk("R7 ovf_err sticky", int'(ovf_err), ovf_exp);
        end
      end
    end
    dma_wr_en = 1'b1;

    // Output ring sweep: R3 R4 R6 R8 R9 R11
    for (int si = 0; si < 2; si++) begin
      for (int code = 0; code < 4; code++) begin
        int osz, n, rp, unread, eflag_now, eflag_new, unf_exp, last, exp_dma;
        osz = (si == 0) ? 4 : 11;
        rst_lo();
        out_size  = AW'(osz);
        empty_wm  = 2'(code);
        eng_dest  = '0;
        dma_rd_en = code[1];
        rst_hi();
        settle(4);
        chk("R3 out_empty drained", int'(out_empty), 1);
        chk("R6 rd_irq drained", int'(rd_irq), 0);
        n = osz - 1;
        for (int j = 0; j < n; j++) eng_put(j, 16'(16'h3000 + osz * 64 + code * 16 + j));
        @(negedge clk);
        eng_dest = AW'(n);
        settle(3);
        rp = 0;
        eflag_now = (n < thr(code)) ? 1 : 0;
        chk("R3 out_empty filled", int'(out_empty), eflag_now);
        chk("R6 rd_irq filled", int'(rd_irq), 1 - eflag_now);
        unf_exp = 0;
        last = 0;
        for (int j = 0; j <= n; j++) begin
          unread = mdiff(n, rp, osz);
          do_read();
          if (unread > 0) begin
            last = 16'h3000 + osz * 64 + code * 16 + rp;
            rp = rp + 1;
            chk("R8 R11 rd_data", int'(rd_data), last);
          end else begin
            unf_exp = 1;
            chk("R9 rd_data held", int'(rd_data), last);
          end
          unread = mdiff(n, rp, osz);
          eflag_new = (unread < thr(code)) ? 1 : 0;
          settle(2);
          chk("R4 out_empty lag", int'(out_empty), eflag_now);
          settle(1);
          chk("R3 R4 out_empty", int'(out_empty), eflag_new);
          exp_dma = (code >= 2 && eflag_new == 0) ? 1 : 0;
          chk("R6 rd_dma", int'(rd_dma), exp_dma);
          chk("R9 unf_err", int'(unf_err), unf_exp);
          eflag_now = eflag_new;
        end
        // R8: read pointer wraps from the last slot to slot 0
        eng_put(n, 16'(16'h5A00 + osz + code));
        @(negedge clk);
        eng_dest = '0;
        do_read();
        chk("R8 wrap read", int'(rd_data), 16'h5A00 + osz + code);
        do_read();
        chk("R9 rd_data held after wrap", int'(rd_data), 16'h5A00 + osz + code);
        chk("R9 unf_err sticky", int'(unf_err), 1);
        settle(3);
        chk("R3 out_empty after wrap", int'(out_empty), 1);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule